// File: doc/BRIEF.md
# Lane-Split Equality Comparator

This block compares two operands of the same width and reports equality per lane, where the lanes are chosen at run time. The word is cut at build time into a fixed list of segments. Every segment has the same width except the top one, which takes all remaining bits. A vector of split-enable bits, one for each internal boundary, chooses which boundaries actually divide the word. Adjacent segments with no active boundary between them form one lane. The block reports one match flag for each lane.

The block is purely combinational. Each lane's flag appears on the result bit whose index is the lane's lowest segment. Every other result bit is held at zero, so the output is defined for any split pattern. A wide datapath can therefore run one full-width equality test or several narrower independent tests, with no change of hardware.

Top module: `lane_eq_cmp`

## Requirements
- R1: Segment k (k below NSEG-1) covers operand bits [SEG_W*k+SEG_W-1 : SEG_W*k]. The top segment NSEG-1 covers bits [WIDTH-1 : SEG_W*(NSEG-1)]. With the defaults (WIDTH=32, SEG_W=4, NSEG=4) the segments are [3:0], [7:4], [11:8] and [31:12].
- R2: When split bit i is 1, segments i and i+1 are in different lanes. When it is 0, they are in the same lane.
- R3: The result bit at a lane's lowest segment index is 1 exactly when the two operands agree on every bit of every segment in that lane.
- R4: Any result bit whose index is not the lowest segment of some lane is 0.
- R5: With all split bits at 0, result bit 0 is the equality of the complete operands, and all higher result bits are 0.
- R6: With all split bits at 1, result bit k is the equality of segment k alone.
- R7: The result depends only on the present operands and split bits. It holds no state and has no clock.
- R8: A single-bit difference anywhere in a segment, including the uppermost bit of the wide top segment, clears the flag of the lane that holds that segment and no other flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| split | input | NSEG-1 | Split-enable bits; bit i divides segment i from segment i+1 |
| lane_eq | output | NSEG | Per-lane match flags, each at the lane's lowest segment index |

## Verification
The block holds no state, so a fault in the per-segment compare or in the lane chain shows on lane_eq as soon as the inputs settle. A wrong chain link makes one lane absorb a segment from its neighbour, or drop one. That shows up only when a single-bit difference falls in the segment concerned under a particular split pattern. For this reason every bit position is flipped alone under all split patterns. A faulty leader decode shows up as a nonzero bit at a position that is not a lane start, even when the operands are equal.

// File: rtl/lane_eq_pkg.sv
package lane_eq_pkg;

    // Lowest bit index of segment k.
    function automatic int seg_lo(input int k, input int segw);
        return k * segw;
    endfunction

    // Highest bit index of segment k; the top segment runs to the word end.
    function automatic int seg_hi(input int k, input int segw, input int nseg, input int width);
        if (k == nseg - 1) begin
            return width - 1;
        end
        return k * segw + segw - 1;
    endfunction

endpackage

// File: rtl/lane_seg_match.sv
module lane_seg_match
    import lane_eq_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int SEG_W = 4,
    parameter int NSEG  = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [NSEG-1:0]  seg_eq_o
);

    // One equality term per segment (R1).
    for (genvar k = 0; k < NSEG; k++) begin : g_seg
        localparam int LO = seg_lo(k, SEG_W);
        localparam int HI = seg_hi(k, SEG_W, NSEG, WIDTH);
        assign seg_eq_o[k] = (a_i[HI:LO] == b_i[HI:LO]);
    end

endmodule

// File: rtl/lane_chain.sv
module lane_chain #(
    parameter int NSEG = 4
) (
    input  logic [NSEG-1:0] seg_eq_i,
    input  logic [NSEG-2:0] split_i,
    output logic [NSEG-1:0] lane_eq_o
);

    logic [NSEG-1:0] cut_above;   // boundary above segment j is active
    logic [NSEG-1:0] lead;        // segment j starts a lane
    logic [NSEG-1:0] run_d;       // segments j.. up to the lane end all match

    assign cut_above = {1'b1, split_i};
    assign lead      = {split_i, 1'b1};

    // AND chain from the top down, restarted at each active boundary (R2, R3).
    always_comb begin
        logic acc;
        acc   = 1'b1;
        run_d = '0;
        for (int j = NSEG - 1; j >= 0; j--) begin
            acc      = seg_eq_i[j] & (cut_above[j] | acc);
            run_d[j] = acc;
        end
    end

    // Only lane leaders report (R4).
    assign lane_eq_o = run_d & lead;

endmodule

// File: rtl/lane_eq_cmp.sv
module lane_eq_cmp
    import lane_eq_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int SEG_W = 4,
    parameter int NSEG  = 4
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [NSEG-2:0]  split,
    output logic [NSEG-1:0]  lane_eq
);

    localparam int TOP_LO = seg_lo(NSEG - 1, SEG_W);

    logic [NSEG-1:0] seg_eq;

    lane_seg_match #(
        .WIDTH (WIDTH),
        .SEG_W (SEG_W),
        .NSEG  (NSEG)
    ) u_match (
        .a_i      (op_a),
        .b_i      (op_b),
        .seg_eq_o (seg_eq)
    );

    lane_chain #(
        .NSEG (NSEG)
    ) u_chain (
        .seg_eq_i  (seg_eq),
        .split_i   (split),
        .lane_eq_o (lane_eq)
    );

    // Combinational checks on the outputs against the inputs (R7: no clock exists).
    always_comb begin
        AST_NONLEAD_ZERO: assert ((lane_eq & ~{split, 1'b1}) == '0); // R4
        if (op_a == op_b) begin
            AST_EQUAL_ALL_LEADERS: assert (lane_eq == {split, 1'b1}); // R3
        end
        if (split == '0) begin
            AST_WHOLE_WORD: assert (lane_eq == {{(NSEG-1){1'b0}}, (op_a == op_b)}); // R5
        end
        if (&split) begin
            AST_TOP_ALONE: assert (lane_eq[NSEG-1] == (op_a[WIDTH-1:TOP_LO] == op_b[WIDTH-1:TOP_LO])); // R6
        end
    end

endmodule

// File: tb/lane_eq_cmp_tb.sv
module lane_eq_cmp_tb;

    localparam int WIDTH = 32;
    localparam int SEG_W = 4;
    localparam int NSEG  = 4;

    logic             clk = 1'b0;
    logic [WIDTH-1:0] op_a;
    logic [WIDTH-1:0] op_b;
    logic [NSEG-2:0]  split;
    logic [NSEG-1:0]  lane_eq;
    int               checks = 0;
    int               errors = 0;
    bit               done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    lane_eq_cmp #(.WIDTH(WIDTH), .SEG_W(SEG_W), .NSEG(NSEG)) u_dut (
        .op_a    (op_a),
        .op_b    (op_b),
        .split   (split),
        .lane_eq (lane_eq)
    );

    // Segment of bit position p, from R1.
    function automatic int seg_of(input int p);
        int s;
        s = p / SEG_W;
        if (s > NSEG - 1) s = NSEG - 1;
        return s;
    endfunction

    // Reference model built from R1..R4.
    function automatic logic [NSEG-1:0] model(input logic [WIDTH-1:0] a,
                                              input logic [WIDTH-1:0] b,
                                              input logic [NSEG-2:0]  g);
        logic [NSEG-1:0] r;
        r = '0;
        for (int s = 0; s < NSEG; s++) begin
            if (s == 0 || g[s-1]) r[s] = 1'b1;
        end
        for (int p = 0; p < WIDTH; p++) begin
            if (a[p] != b[p]) begin
                int start;
                start = seg_of(p);
                while (start > 0 && !g[start-1]) start--;
                r[start] = 1'b0;
            end
        end
        return r;
    endfunction

    task automatic apply_check(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                               input logic [NSEG-2:0] g, input logic [NSEG-1:0] exp,
                               input string tag);
        @(negedge clk);
        op_a  = a;
        op_b  = b;
        split = g;
        #2;
        checks++;
        if (lane_eq !== exp) begin
            errors++;
            $display("FAIL %s: a=%h b=%h split=%b actual=%b expected=%b",
                     tag, a, b, g, lane_eq, exp);
        end
    endtask

    // Idle state: zero operands, no splits.
    task automatic t_idle();
        apply_check('0, '0, '0, 4'b0001, "R5");
    endtask

    // Equal operands under every split pattern: all leaders high, rest low.
    task automatic t_equal_sweep();
        for (int g = 0; g < (1 << (NSEG-1)); g++) begin
            apply_check(32'hDEAD_BEEF, 32'hDEAD_BEEF, g[NSEG-2:0],
                        {g[NSEG-2:0], 1'b1}, "R4");
        end
    endtask

    // Directed lanes from R2/R3 for one-gate patterns.
    task automatic t_directed_lanes();
        // gate0 only: bit1 covers segs 1..3; diff in seg 2
        apply_check(32'h0000_0000, 32'h0000_0100, 3'b001, 4'b0001, "R3");
        // gate1 only: diff in seg 1 clears bit0 only
        apply_check(32'h0000_0000, 32'h0000_0010, 3'b010, 4'b0100, "R2");
        // gate2 only: diff in seg 3 clears bit3 only
        apply_check(32'h0000_0000, 32'h0001_0000, 3'b100, 4'b0001, "R2");
        // gate2 only: diff in seg 2 clears bit0
        apply_check(32'h0000_0000, 32'h0000_0800, 3'b100, 4'b1000, "R3");
    endtask

    // No splits: whole word equality.
    task automatic t_whole_word();
        apply_check(32'h1234_5678, 32'h1234_5678, 3'b000, 4'b0001, "R5");
        apply_check(32'h1234_5678, 32'h9234_5678, 3'b000, 4'b0000, "R5");
    endtask

    // All splits: per segment equality, including the wide top segment.
    task automatic t_all_split();
        apply_check(32'hFFFF_F000, 32'h0000_0000, 3'b111, 4'b0111, "R6");
        apply_check(32'h0000_0A5A, 32'h0000_0A5B, 3'b111, 4'b1110, "R6");
        apply_check(32'h0000_0A5A, 32'h0000_0B5A, 3'b111, 4'b1011, "R1");
    endtask

    // Every single-bit difference under every split pattern.
    task automatic t_single_bit();
        for (int g = 0; g < (1 << (NSEG-1)); g++) begin
            for (int p = 0; p < WIDTH; p++) begin
                logic [WIDTH-1:0] b;
                b = 32'h5A5A_C3C3 ^ (32'h1 << p);
                apply_check(32'h5A5A_C3C3, b, g[NSEG-2:0],
                            model(32'h5A5A_C3C3, b, g[NSEG-2:0]), "R8");
            end
        end
    endtask

    // Random operands with sparse differences; result follows inputs each step.
    task automatic t_random();
        for (int n = 0; n < 300; n++) begin
            logic [WIDTH-1:0] a, b;
            logic [NSEG-2:0]  g;
            a = $urandom();
            b = a ^ (($urandom() & $urandom() & $urandom()));
            g = $urandom();
            apply_check(a, b, g, model(a, b, g), "R7");
        end
    endtask

    initial begin
        op_a  = '0;
        op_b  = '0;
        split = '0;
        repeat (2) @(posedge clk);
        t_idle();
        t_equal_sweep();
        t_directed_lanes();
        t_whole_word();
        t_all_split();
        t_single_bit();
        t_random();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule